// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor and a word-wide memory and keeps the most recently used 16-byte blocks of memory in 64 lines. Each line has a valid flag, a dirty flag, a stored tag and four 32-bit words. The processor asks for one word at a time with a 32-bit byte address. The cache splits that address into a tag, a line index and a word select. Only one line can hold a given block, so a hit needs just one tag compare.

A request is accepted while the controller is idle, and the cache reports the outcome one cycle later. A hit finishes in that cycle. A miss raises the stall output and runs the memory handshake. If the line being replaced holds modified data, the controller first writes its four words back to memory. It then reads the four words of the requested block. After the refill the access is compared again and finishes as a hit. Writes that hit change only the cached copy and mark the line modified. Writes that miss first allocate the line and then merge the new word.

Top module: `dmc_cache_top`

## Requirements
- R1: The address fields are: tag = bits 31:10, line index = bits 9:4, word select = bits 3:2. Bits 1:0 have no effect. For example, byte address 1200 uses line 11, and its refill reads start at byte address 1200 (0x4B0).
- R2: After a synchronous active-low reset, `cpu_stall`, `cpu_done` and `mem_req` are low and every line is invalid, so the first access to any line misses.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_done` in the cycle after the request is accepted and causes no memory traffic.
- R4: When `cpu_done` is high for a read, `cpu_rdata` holds the word chosen by the word select. That word is the last value written to it, or the memory value if it was never written.
- R5: A miss whose victim is invalid or clean makes exactly four memory reads. They cover the requested block in ascending word order, words 0 to 3, and there are no memory writes. Each beat keeps `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.
- R6: A write hit changes only the cached line, makes no memory access and marks the line dirty.
- R7: A miss whose victim is valid and dirty first makes four memory writes. These carry the victim's words in ascending order to the victim's own block address. No refill read happens before the fourth write.
- R8: `cpu_stall` is high in every cycle from the miss report until the access completes, and it is low in the cycle where `cpu_done` is high.
- R9: A write miss refills the line first, then merges the written word. The line ends up dirty, and later reads return the written word.
- R10: A line filled by a read miss enters clean with the new tag, so replacing it later causes no writeback.
- R11: `cpu_miss` is high for exactly one cycle for each access that misses, and never at the same time as `cpu_done`. `cpu_hit` is high with `cpu_done` only when the first compare hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, accepted when the controller is idle |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Access completed on its first compare |
| cpu_miss | output | 1 | Miss detected; service begins |
| cpu_stall | output | 1 | Processor must wait |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Writeback data |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted / data returned |

## Verification
The bench first runs a directed sequence:
- a cold read of address 1200, which shows the index decode and the refill order;
- repeat reads at other word selects and byte offsets, which show that hit detection ignores bits 1:0;
- a write hit, which must cause no memory traffic;
- a conflicting tag on line 11, which must trigger a writeback and so separates the dirty and clean victim paths;
- a write miss followed by eviction, which shows the write allocate and the dirty marking.

After that it runs seeded random reads and writes over four tags and eight lines with random memory ack delays. This mix produces hits, clean-victim misses and dirty-victim misses back to back. For each access, a reference model of the valid, tag and dirty flags predicts the following, and the bench compares each prediction against the outputs:
- whether the access hits;
- how many write and read beats it causes;
- the address and data of every beat;
- the returned word.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
// Package: types shared by the cache controller modules.
// Assumes: nothing beyond a single clock domain.
package dmc_pkg;

    // Controller phases; encoding is internal only.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_WB   = 2'd2,
        ST_FILL = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
`timescale 1ns/1ps
// Module: dmc_addr_split
// Splits a word address (byte bits already dropped) into tag, line index
// and word select. Pure wiring; assumes the line count and words per line
// are powers of two so that the fields are plain bit ranges.
module dmc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 2,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W
) (
    input  logic [ADDR_W-1:BYTE_W] word_addr,
    output logic [TAG_W-1:0]       tag,
    output logic [IDX_W-1:0]       idx,
    output logic [WSEL_W-1:0]      wsel
);

    localparam int IDX_LO = BYTE_W + WSEL_W;
    localparam int TAG_LO = IDX_LO + IDX_W;

    // Field extraction: word select lowest, index above it, tag on top.
    assign wsel = word_addr[IDX_LO-1:BYTE_W];
    assign idx  = word_addr[TAG_LO-1:IDX_LO];
    assign tag  = word_addr[ADDR_W-1:TAG_LO];

endmodule

// File: rtl/dmc_line_store.sv
`timescale 1ns/1ps
// Module: dmc_line_store
// Holds per-line valid/dirty flags, tags and data words. One index serves
// both the read port and the write port, since an access only ever touches
// one line. Reads are combinational; writes land on the clock edge.
// Assumes: fill_done and mark_dirty are never high together.
module dmc_line_store #(
    parameter int LINES  = 64,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 22,
    parameter int WORDS  = 4,
    parameter int WSEL_W = 2,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               line_idx,
    output logic                           rd_valid,
    output logic                           rd_dirty,
    output logic [TAG_W-1:0]               rd_tag,
    output logic [WORDS-1:0][WORD_W-1:0]   rd_line,
    input  logic                           wr_en,
    input  logic [WSEL_W-1:0]              wr_sel,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic                           mark_dirty,
    input  logic                           fill_done,
    input  logic [TAG_W-1:0]               fill_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flag update: reset clears all lines; a fill validates and cleans, a write hit dirties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_done) begin
            valid_q[line_idx] <= 1'b1;
            dirty_q[line_idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[line_idx] <= 1'b1;
        end
    end

    // Tag update: written only when a refill completes.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[line_idx] <= fill_tag;
        end
    end

    assign rd_valid = valid_q[line_idx];
    assign rd_dirty = dirty_q[line_idx];
    assign rd_tag   = tag_q[line_idx];

    // One storage column per word position inside a line.
    for (genvar w = 0; w < WORDS; w++) begin : g_col
        logic [WORD_W-1:0] col_q [LINES];

        // Column write: takes the word when this column is selected.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == WSEL_W'(w))) begin
                col_q[line_idx] <= wr_data;
            end
        end

        assign rd_line[w] = col_q[line_idx];
    end

endmodule

// File: rtl/dmc_fsm.sv
`timescale 1ns/1ps
// Module: dmc_fsm
// Sequencing for one outstanding access: compare, optional writeback of a
// dirty victim, refill, then compare again. The beat counter walks the
// words of a line in ascending order during writeback and refill.
// Assumes: the request inputs stay stable (registered upstream) while busy.
module dmc_fsm
    import dmc_pkg::*;
#(
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ack,
    output dmc_state_e        state,
    output logic [WSEL_W-1:0] beat,
    output logic              refilled
);

    logic last_beat;
    assign last_beat = &beat;

    // State, beat and refill-flag progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat     <= '0;
            refilled <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_CMP;
                        refilled <= 1'b0;
                    end
                end
                ST_CMP: begin
                    beat <= '0;
                    if (hit) begin
                        state <= ST_IDLE;
                    end else if (victim_dirty) begin
                        state <= ST_WB;
                    end else begin
                        state <= ST_FILL;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        beat <= last_beat ? '0 : beat + 1'b1;
                        if (last_beat) begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat <= last_beat ? '0 : beat + 1'b1;
                        if (last_beat) begin
                            state    <= ST_CMP;
                            refilled <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmc_cache_top.sv
`timescale 1ns/1ps
// Module: dmc_cache_top
// Direct-mapped, write-back, write-allocate data cache. It holds the
// accepted request, decodes it, looks up the line store and drives the
// memory handshake from the controller's state.
// Assumes: the processor presents a request only while cpu_stall and
// cpu_done are low and waits for cpu_done. The memory answers each beat
// with a one-cycle mem_ack and returns read data alongside it.
module dmc_cache_top
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              cpu_miss,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int BYTE_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - WSEL_W - BYTE_W;

    dmc_state_e                 state;
    logic [WSEL_W-1:0]          beat;
    logic                       refilled;
    logic                       req_we;
    logic [ADDR_W-1:BYTE_W]     req_waddr;
    logic [WORD_W-1:0]          req_wdata;
    logic [TAG_W-1:0]           req_tag;
    logic [IDX_W-1:0]           req_idx;
    logic [WSEL_W-1:0]          req_wsel;
    logic                       rd_valid;
    logic                       rd_dirty;
    logic [TAG_W-1:0]           rd_tag;
    logic [WORDS-1:0][WORD_W-1:0] rd_line;
    logic                       tag_match;
    logic                       accept;
    logic                       fill_ack;
    logic                       wr_en;
    logic [WSEL_W-1:0]          wr_sel;
    logic [WORD_W-1:0]          wr_data;
    logic                       mark_dirty;
    logic                       fill_done;
    logic                       unused_byte_bits;

    // Byte-within-word bits carry no meaning for word accesses.
    assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

    assign accept = (state == ST_IDLE) && cpu_req;

    // Request capture: holds the access steady for its whole service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_waddr <= '0;
            req_wdata <= '0;
        end else if (accept) begin
            req_we    <= cpu_we;
            req_waddr <= cpu_addr[ADDR_W-1:BYTE_W];
            req_wdata <= cpu_wdata;
        end
    end

    dmc_addr_split #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .WSEL_W (WSEL_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) i_split (
        .word_addr (req_waddr),
        .tag       (req_tag),
        .idx       (req_idx),
        .wsel      (req_wsel)
    );

    dmc_line_store #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .WORDS  (WORDS),
        .WSEL_W (WSEL_W),
        .WORD_W (WORD_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_idx   (req_idx),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_tag     (rd_tag),
        .rd_line    (rd_line),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .mark_dirty (mark_dirty),
        .fill_done  (fill_done),
        .fill_tag   (req_tag)
    );

    dmc_fsm #(
        .WSEL_W (WSEL_W)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .hit          (tag_match),
        .victim_dirty (rd_valid && rd_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .beat         (beat),
        .refilled     (refilled)
    );

    // Hit detection: valid line with matching tag.
    assign tag_match = rd_valid && (rd_tag == req_tag);

    // Processor-side status.
    assign cpu_done  = (state == ST_CMP) && tag_match;
    assign cpu_miss  = (state == ST_CMP) && !tag_match;
    assign cpu_hit   = cpu_done && !refilled;
    assign cpu_stall = (state != ST_IDLE) && !cpu_done;
    assign cpu_rdata = rd_line[req_wsel];

    // Line write steering: refill beats or a merged processor write.
    assign fill_ack   = (state == ST_FILL) && mem_ack;
    assign mark_dirty = cpu_done && req_we;
    assign fill_done  = fill_ack && (&beat);
    assign wr_en      = fill_ack || mark_dirty;
    assign wr_sel     = (state == ST_FILL) ? beat : req_wsel;
    assign wr_data    = (state == ST_FILL) ? mem_rdata : req_wdata;

    // Memory port: victim tag on writeback, request tag on refill.
    assign mem_req   = (state == ST_WB) || (state == ST_FILL);
    assign mem_we    = (state == ST_WB);
    assign mem_addr  = {((state == ST_WB) ? rd_tag : req_tag), req_idx, beat, BYTE_W'(0)};
    assign mem_wdata = rd_line[beat];

endmodule

// File: rtl/dmc_cache_chk.sv
`timescale 1ns/1ps
// Module: dmc_cache_chk
// Protocol and ordering properties over the cache's ports, bound to every
// instance of dmc_cache_top.
// Assumes: a synchronous active-low reset and one clock.
module dmc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              cpu_hit,
    input logic              cpu_miss,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    // Outputs are quiet right after reset.
    p_idle_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !cpu_stall));

    // A first-try hit never uses the memory port.
    p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> !mem_req);

    // A pending beat holds its request, direction and address.
    p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // Acknowledged non-final beats advance to the next word.
    p_beat_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[BYTE_W +: WSEL_W] != '1)) |=>
        (mem_req && (mem_addr[BYTE_W +: WSEL_W] == WSEL_W'($past(mem_addr[BYTE_W +: WSEL_W]) + 1'b1))));

    // No writeback beat follows a refill beat.
    p_wb_before_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && mem_we));

    // Miss report stalls; completion releases the stall.
    p_miss_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_miss |-> cpu_stall);
    p_done_unstalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_stall);

    // Miss and done are exclusive; a miss is followed by service, not completion.
    p_miss_not_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_miss |-> !cpu_done);
    p_miss_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_miss |=> !cpu_miss);

endmodule

bind dmc_cache_top dmc_cache_chk #(
    .ADDR_W (32),
    .BYTE_W (2),
    .WSEL_W (2)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_done  (cpu_done),
    .cpu_hit   (cpu_hit),
    .cpu_miss  (cpu_miss),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/test_dmc_cache_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random accesses. A reference
// model of line flags and a golden memory image predict every outcome.
module test_dmc_cache_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done, cpu_hit, cpu_miss, cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference state.
    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] gold [logic [31:0]];
    bit          m_valid [64];
    bit          m_dirty [64];
    logic [21:0] m_tag [64];
    logic [27:0] exp_wb_base, exp_fill_base;
    int          wr_cnt = 0, rd_cnt = 0, mem_delay = 0;

    always #10 clk = ~clk;

    dmc_cache_top i_dmc_cache_top (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_miss(cpu_miss),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : init_val(a);
    endfunction

    function automatic logic [31:0] gold_word(input logic [31:0] a);
        return gold.exists(a) ? gold[a] : init_val(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Memory model: random ack delay, beat address/data checks, one-cycle ack.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n === 1'b1 && mem_req === 1'b1) begin
            if (mem_delay > 0) begin
                mem_delay--;
            end else begin
                if (mem_we) begin
                    check(rd_cnt == 0, "R7", "write beat after a refill read", rd_cnt, 0);
                    check(mem_addr == {exp_wb_base, wr_cnt[1:0], 2'b00}, "R7",
                          "writeback address", mem_addr, {exp_wb_base, wr_cnt[1:0], 2'b00});
                    check(mem_wdata == gold_word(mem_addr), "R7", "writeback data",
                          mem_wdata, gold_word(mem_addr));
                    mem_img[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    check(mem_addr == {exp_fill_base, rd_cnt[1:0], 2'b00}, "R5",
                          "refill address", mem_addr, {exp_fill_base, rd_cnt[1:0], 2'b00});
                    mem_rdata = mem_word(mem_addr);
                    rd_cnt++;
                end
                mem_ack = 1'b1;
                mem_delay = $urandom % 3;
            end
        end
    end

    // One processor access, with predictions from the reference model.
    task automatic do_access(input logic we, input logic [31:0] addr,
                             input logic [31:0] data, input string ctx);
        logic [31:0] a;
        logic [5:0]  idx;
        logic [21:0] tg;
        bit          pred_hit, pred_wb, first;
        int          cycles;
        a   = {addr[31:2], 2'b00};
        idx = addr[9:4];
        tg  = addr[31:10];
        pred_hit = m_valid[idx] && (m_tag[idx] == tg);
        pred_wb  = !pred_hit && m_valid[idx] && m_dirty[idx];
        exp_wb_base   = {m_tag[idx], idx};
        exp_fill_base = addr[31:4];
        wr_cnt = 0;
        rd_cnt = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = data;
        @(negedge clk);
        cpu_req = 1'b0;
        first = 1;
        cycles = 0;
        while (!cpu_done) begin
            if (first) begin
                check(cpu_miss == !pred_hit, "R11", {ctx, " miss pulse"}, cpu_miss, !pred_hit);
            end
            check(cpu_stall == 1'b1, "R8", {ctx, " stall during service"}, cpu_stall, 1);
            first = 0;
            @(negedge clk);
            cycles++;
            if (cycles > 200) begin
                check(0, "R8", {ctx, " access watchdog"}, cycles, 200);
                return;
            end
        end
        if (pred_hit) begin
            check(cycles == 0, "R3", {ctx, " hit latency"}, cycles, 0);
        end
        check(cpu_hit == pred_hit, "R11", {ctx, " hit flag"}, cpu_hit, pred_hit);
        check(cpu_miss == 1'b0, "R11", {ctx, " miss with done"}, cpu_miss, 0);
        check(cpu_stall == 1'b0, "R8", {ctx, " stall at done"}, cpu_stall, 0);
        if (!we) begin
            check(cpu_rdata == gold_word(a), "R4", {ctx, " read data"}, cpu_rdata, gold_word(a));
        end
        check(wr_cnt == (pred_wb ? 4 : 0), pred_wb ? "R7" : "R6",
              {ctx, " writeback beats"}, wr_cnt, pred_wb ? 4 : 0);
        check(rd_cnt == (pred_hit ? 0 : 4), "R5", {ctx, " refill beats"}, rd_cnt, pred_hit ? 4'd0 : 4'd4);
        m_valid[idx] = 1;
        m_tag[idx]   = tg;
        m_dirty[idx] = pred_hit ? (m_dirty[idx] | we) : we;
        if (we) begin
            gold[a] = data;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 0;
            m_dirty[i] = 0;
            m_tag[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cpu_stall == 1'b0, "R2", "stall after reset", cpu_stall, 0);
        check(cpu_done == 1'b0, "R2", "done after reset", cpu_done, 0);
        check(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);
        rst_n = 1'b1;

        // Directed corner cases.
        do_access(0, 32'd1200, '0, "R2 R1 cold read line 11");
        do_access(0, 32'd1200, '0, "R3 repeat read");
        do_access(0, 32'd1204, '0, "R4 other word");
        do_access(0, 32'd1201, '0, "R1 byte bits ignored");
        do_access(1, 32'd1208, 32'hCAFE_0001, "R6 write hit");
        do_access(0, 32'd1208, '0, "R6 read back");
        do_access(0, 32'd1200 + 32'd1024, '0, "R7 dirty victim");
        do_access(0, 32'd1208, '0, "R10 clean victim");
        do_access(1, 32'h2000_0044, 32'hBEEF_0002, "R9 write miss");
        do_access(0, 32'h2000_0044, '0, "R9 merged read");
        do_access(0, 32'h3000_0040, '0, "R9 evict dirty");
        do_access(0, 32'h2000_0044, '0, "R9 data survived");

        // Seeded random accesses over 4 tags and 8 lines.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            ra = (($urandom % 4) << 10) | (($urandom % 8) << 4) | (($urandom % 4) << 2) | ($urandom % 4);
            do_access(($urandom % 2) == 1, ra, $urandom, "random");
        end
        summary();
    end

    // Global watchdog: counts as a failed check.
    initial begin
        #(20 * 150000);
        check(0, "R8", "global watchdog", 0, 1);
        summary();
    end

endmodule